// File: doc/BRIEF.md
# Cascadable Loadable Binary Counter

This block is an 8-bit synchronous up-counter built from two identical 4-bit counter cells. Each cell has a synchronous clear, a synchronous parallel load, and a carry output. The carry output is high while the cell holds its all-ones value and its count input is active. The upper cell counts only when the lower cell's carry is high, so the pair steps as one binary value. Every change of state happens on the rising clock edge.

A small control unit sits in front of the cells and turns the plain counter into an offset counter. A two-bit wrap selector chooses the mode. In start-offset mode, the carry out of the top cell triggers a reload of a programmed start value, so after 0xFF the count goes back to that value rather than to zero. In end-offset mode, a comparator watches for a programmed end value and sends the count to zero on the next edge. The control unit drives the cells only through a small set of strobes: clear, load and advance.

Top module: `cascade_counter`

## Requirements
- R1: When `clear` is high at a rising edge, `count` is 0x00 after that edge, whatever `load`, `enable` and `wrapMode` are.
- R2: When `load` is high and `clear` is low at a rising edge, `count` equals `loadData` after that edge. This load takes priority over `enable` and over both wrap actions.
- R3: When `clear`, `load` and `enable` are all low at a rising edge, `count` does not change, in every wrap mode.
- R4: In plain mode (`wrapMode` 2'b00 or 2'b11), an edge with only `enable` high adds one to `count` modulo 256, so 0xFF is followed by 0x00.
- R5: `carryOut` is high exactly when `count` is 0xFF, `enable` is high, and `clear` and `load` are low.
- R6: Bits 7:4 advance by one on an edge exactly when bits 3:0 are 0xF and counting is enabled. Otherwise the upper nibble keeps its value while counting.
- R7: In start-offset mode (`wrapMode` 2'b01), an enabled edge at `count` 0xFF loads `startVal`. Other enabled edges add one.
- R8: In end-offset mode (`wrapMode` 2'b10), an enabled edge at `count` equal to `endVal` sets `count` to 0x00. Other enabled edges add one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear to zero, highest priority |
| load | input | 1 | Synchronous parallel load of `loadData` |
| enable | input | 1 | Count enable |
| wrapMode | input | 2 | 00/11 plain, 01 start-offset, 10 end-offset |
| loadData | input | 8 | Parallel load value |
| startVal | input | 8 | Value reloaded after 0xFF in start-offset mode |
| endVal | input | 8 | Last value before the return to zero in end-offset mode |
| count | output | 8 | Current count |
| carryOut | output | 1 | Cascade carry, high at 0xFF while counting is enabled |

## Verification
The rarest event at the ports is the carry from the low cell into the high cell at the 0xFF terminal state. In start-offset mode the same terminal state must load a value instead of rolling over. A plain sweep needs 256 enabled cycles to reach the terminal state once. The bench therefore runs one full enabled sweep and then uses parallel load to jump close to 0xFF and to each nibble boundary. From there it runs both offset sequences through several wraps and compares each cycle against values computed in the bench.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

  // Strobes from the wrap control to the counter cells.
  typedef struct packed {
    logic clr;   // force zero
    logic ld;    // take load value
    logic adv;   // count qualifier into the lowest cell
  } cnt_strobe_t;

  localparam logic [1:0] MODE_PLAIN = 2'b00;
  localparam logic [1:0] MODE_START = 2'b01;
  localparam logic [1:0] MODE_END   = 2'b10;

endpackage

// File: rtl/cnt_cell.sv
module cnt_cell #(
  parameter int CELL_W = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              ld,
  input  logic              cin,
  input  logic [CELL_W-1:0] d,
  output logic [CELL_W-1:0] q,
  output logic              cout
);

  // Bit i flips when the count input is active and all lower bits are one.
  logic [CELL_W-1:0] flip;

  assign flip[0] = cin;
  genvar gi;
  generate
    for (gi = 1; gi < CELL_W; gi++) begin : g_flip
      assign flip[gi] = flip[gi-1] & q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr)     q <= '0;
    else if (ld) q <= d;
    else         q <= q ^ flip;
  end

  assign cout = cin & (&q);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
  import cascade_counter_pkg::*;
#(
  parameter int CELL_W    = 4,
  parameter int NUM_CELLS = 2,
  localparam int TOTAL_W  = CELL_W * NUM_CELLS
) (
  input  logic               clk,
  input  cnt_strobe_t        strobe,
  input  logic [TOTAL_W-1:0] ldValue,
  output logic [TOTAL_W-1:0] count,
  output logic               carryOut
);

  logic [NUM_CELLS:0] carryChain;

  assign carryChain[0] = strobe.adv;

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CELLS; gc++) begin : g_cell
      cnt_cell #(.CELL_W(CELL_W)) u_cell (
        .clk  (clk),
        .clr  (strobe.clr),
        .ld   (strobe.ld),
        .cin  (carryChain[gc]),
        .d    (ldValue[gc*CELL_W +: CELL_W]),
        .q    (count[gc*CELL_W +: CELL_W]),
        .cout (carryChain[gc+1])
      );
    end
  endgenerate

  assign carryOut = carryChain[NUM_CELLS];

endmodule

// File: rtl/cnt_wrap_ctrl.sv
module cnt_wrap_ctrl
  import cascade_counter_pkg::*;
#(
  parameter int TOTAL_W = 8
) (
  input  logic               clear,
  input  logic               load,
  input  logic               enable,
  input  logic [1:0]         wrapMode,
  input  logic [TOTAL_W-1:0] loadData,
  input  logic [TOTAL_W-1:0] startVal,
  input  logic [TOTAL_W-1:0] endVal,
  input  logic [TOTAL_W-1:0] count,
  input  logic               carryOut,
  output cnt_strobe_t        strobe,
  output logic [TOTAL_W-1:0] ldValue
);

  logic startWrap;
  logic endWrap;

  // The top cell's carry marks the terminal state; it triggers the reload.
  assign startWrap = (wrapMode == MODE_START) & carryOut;
  assign endWrap   = (wrapMode == MODE_END) & enable & (count == endVal);

  always_comb begin
    strobe.adv = enable & ~clear & ~load;
    strobe.clr = clear | (~load & endWrap);
    strobe.ld  = ~clear & (load | startWrap);
    ldValue    = load ? loadData : startVal;
  end

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_counter_pkg::*;
#(
  parameter int CELL_W    = 4,
  parameter int NUM_CELLS = 2,
  localparam int TOTAL_W  = CELL_W * NUM_CELLS
) (
  input  logic               clk,
  input  logic               clear,
  input  logic               load,
  input  logic               enable,
  input  logic [1:0]         wrapMode,
  input  logic [TOTAL_W-1:0] loadData,
  input  logic [TOTAL_W-1:0] startVal,
  input  logic [TOTAL_W-1:0] endVal,
  output logic [TOTAL_W-1:0] count,
  output logic               carryOut
);

  cnt_strobe_t        strobe;
  logic [TOTAL_W-1:0] ldValue;

  cnt_wrap_ctrl #(.TOTAL_W(TOTAL_W)) u_ctrl (
    .clear    (clear),
    .load     (load),
    .enable   (enable),
    .wrapMode (wrapMode),
    .loadData (loadData),
    .startVal (startVal),
    .endVal   (endVal),
    .count    (count),
    .carryOut (carryOut),
    .strobe   (strobe),
    .ldValue  (ldValue)
  );

  cnt_chain #(.CELL_W(CELL_W), .NUM_CELLS(NUM_CELLS)) u_chain (
    .clk      (clk),
    .strobe   (strobe),
    .ldValue  (ldValue),
    .count    (count),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/cascade_counter_checker.sv
module cascade_counter_checker #(
  parameter int CELL_W  = 4,
  parameter int TOTAL_W = 8
) (
  input logic               clk,
  input logic               clear,
  input logic               load,
  input logic               enable,
  input logic [1:0]         wrapMode,
  input logic [TOTAL_W-1:0] loadData,
  input logic [TOTAL_W-1:0] startVal,
  input logic [TOTAL_W-1:0] endVal,
  input logic [TOTAL_W-1:0] count,
  input logic               carryOut
);

  // Armed by the first clear; before that the count is unknown.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | clear;

  logic plainMode;
  logic countOnly;
  assign plainMode = (wrapMode == 2'b00) | (wrapMode == 2'b11);
  assign countOnly = enable & ~clear & ~load;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
    clear |=> count == '0);  // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed)
    (load && !clear) |=> count == $past(loadData));  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed)
    (!clear && !load && !enable) |=> $stable(count));  // R3

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!armed)
    (countOnly && plainMode) |=> count == TOTAL_W'($past(count) + 1'b1));  // R4

  AST_CARRY_TERM: assert property (@(posedge clk) disable iff (!armed)
    carryOut |-> (countOnly && (&count)));  // R5

  AST_NIBBLE_CARRY: assert property (@(posedge clk) disable iff (!armed)
    (countOnly && plainMode && (&count[CELL_W-1:0]) && !(&count))
      |=> count[TOTAL_W-1:CELL_W] == $past(count[TOTAL_W-1:CELL_W]) + 1'b1);  // R6

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!armed)
    (countOnly && wrapMode == 2'b01 && (&count)) |=> count == $past(startVal));  // R7

  AST_END_WRAP: assert property (@(posedge clk) disable iff (!armed)
    (countOnly && wrapMode == 2'b10 && count == endVal) |=> count == '0);  // R8

endmodule

bind cascade_counter cascade_counter_checker #(.CELL_W(CELL_W), .TOTAL_W(TOTAL_W)) u_checker (
  .clk      (clk),
  .clear    (clear),
  .load     (load),
  .enable   (enable),
  .wrapMode (wrapMode),
  .loadData (loadData),
  .startVal (startVal),
  .endVal   (endVal),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/cascade_counter_bench.sv
`timescale 1ns/1ps
module cascade_counter_bench;

  logic       clk = 1'b0;
  logic       clear = 1'b0;
  logic       load = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] wrapMode = 2'b00;
  logic [7:0] loadData = 8'h00;
  logic [7:0] startVal = 8'h00;
  logic [7:0] endVal = 8'h00;
  logic [7:0] count;
  logic       carryOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model = 8'h00;

  always #2.5 clk = ~clk;

  cascade_counter u_cascade_counter (
    .clk(clk), .clear(clear), .load(load), .enable(enable),
    .wrapMode(wrapMode), .loadData(loadData), .startVal(startVal),
    .endVal(endVal), .count(count), .carryOut(carryOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected next count, from the requirements.
  function automatic logic [7:0] nextCount(input logic [7:0] cur);
    if (clear) return 8'h00;                                   // R1
    if (load) return loadData;                                 // R2
    if (!enable) return cur;                                   // R3
    if (wrapMode == 2'b01 && cur == 8'hFF) return startVal;    // R7
    if (wrapMode == 2'b10 && cur == endVal) return 8'h00;      // R8
    return cur + 8'h01;                                        // R4
  endfunction

  // Inputs are already set; check carry now, clock once, check count.
  task automatic step(input string req);
    logic expCarry;
    expCarry = enable && !clear && !load && (model == 8'hFF);
    check("R5 carry", {7'd0, carryOut}, {7'd0, expCarry});
    model = nextCount(model);
    @(posedge clk); #1;
    check(req, count, model);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    @(posedge clk); #1;
    // R1 clear with load and enable also asserted
    clear = 1; load = 1; enable = 1; loadData = 8'h5A;
    model = 8'h00;
    @(posedge clk); #1;
    check("R1 clear wins", count, 8'h00);
    clear = 0; load = 0; enable = 0;
    check("R5 idle carry", {7'd0, carryOut}, 8'h00);

    // R4/R6 full enabled sweep in plain mode, 0x00 back to 0x00
    enable = 1; wrapMode = 2'b00;
    for (int i = 0; i < 256; i++) step("R4 R6 sweep");
    check("R4 rollover", count, 8'h00);

    // R2 load over enable
    load = 1; loadData = 8'hA5; step("R2 load"); load = 0;
    // R3 hold in every mode
    enable = 0;
    for (int m = 0; m < 4; m++) begin
      wrapMode = 2'(m); step("R3 hold");
    end
    // R5 at 0xFF with enable low: no carry
    load = 1; loadData = 8'hFF; step("R2 load FF"); load = 0;
    step("R3 hold FF");
    // R2 load beats start-offset reload at 0xFF
    enable = 1; wrapMode = 2'b01; startVal = 8'hF6;
    load = 1; loadData = 8'h3C; step("R2 load over wrap"); load = 0;

    // R6 nibble boundaries with the mode-11 plain variant
    wrapMode = 2'b11;
    for (int n = 0; n < 15; n++) begin
      load = 1; loadData = {4'(n), 4'hE}; step("R2 preload"); load = 0;
      step("R6 to F"); step("R6 nibble carry");
    end

    // R7 start-offset sequence, several wraps
    wrapMode = 2'b01; startVal = 8'hF6;
    load = 1; loadData = 8'hFB; step("R2 preload"); load = 0;
    for (int i = 0; i < 40; i++) step("R7 start offset");
    // R7 start value 0x00 degenerates to plain rollover
    startVal = 8'h00;
    for (int i = 0; i < 20; i++) step("R7 start zero");

    // R8 end-offset sequence
    wrapMode = 2'b10; endVal = 8'h0D;
    clear = 1; step("R1 clear"); clear = 0;
    for (int i = 0; i < 45; i++) step("R8 end offset");
    // R8 end value at 0xFF, carry still reported
    endVal = 8'hFF;
    load = 1; loadData = 8'hFC; step("R2 preload"); load = 0;
    for (int i = 0; i < 8; i++) step("R8 end at FF");
    // R2 load over end wrap
    endVal = 8'h20;
    load = 1; loadData = 8'h20; step("R2 preload"); load = 0;
    load = 1; loadData = 8'h77; step("R2 load over end"); load = 0;

    // R3 enable toggling in end mode
    for (int i = 0; i < 30; i++) begin
      enable = (i % 3) != 0; step("R3 R8 gated");
    end
    finish();
  end

endmodule